// File: doc/BRIEF.md
# Add-only memory read engine with CRC-8

This block carries out the three read commands of an add-only memory device. It sits above a byte-level slave link, so bit timing is handled elsewhere. The master sends a command byte and then a two-byte target address, low byte first. The block answers with a CRC-8 over those three bytes. It then streams bytes from a 128-byte main array or an 8-byte status array, one byte for each read slot the master requests.

The command selects where CRC bytes appear in the stream:
- A whole-memory read sends one CRC after the last byte of the main array.
- A paged read closes each 32-byte page with a CRC over that page's bytes, then goes on with the next page.
- A status read ends with a CRC computed from the status bytes as they are read, so it always matches their current contents.

After the final CRC, every further read slot returns all ones. A line reset from the link layer ends the command at any point and returns the block to waiting for a command.

Both arrays live outside the block. The block drives a read address to each array and takes back the data combinationally.

Top module: `addonly_rd_engine`

## Requirements
- R1: The command bytes F0h (whole-memory read), C3h (paged read) and AAh (status read) are accepted. After any other command byte, every read slot returns FFh until a line reset.
- R2: The first address byte is the low byte and the second is the high byte. Main-array reads start at bits 6:0 of the low byte. Status reads start at bits 2:0 of the low byte. All other address bits are ignored.
- R3: The first read slot after the address returns a CRC-8 over the command byte, the low address byte and the high address byte.
  - The polynomial is x^8+x^5+x^4+1.
  - Bits are shifted in LSB first, starting from a zero state.
  - In reflected form, each bit step XORs 8Ch into the state when the state LSB XOR the data bit is 1.
- R4: Every read slot request (tx_req high for one cycle) is answered by tx_valid high for exactly the next cycle, with the byte on tx_byte. Read slots requested before the address is complete return FFh and change nothing. After reset, tx_valid is low.
- R5: A whole-memory read returns main bytes from the start address up to address 127. It then returns one CRC over exactly those bytes, using a fresh accumulator started after the command CRC.
- R6: A paged read returns main bytes and, after each byte whose address bits 4:0 are all ones, inserts a CRC.
  - The first page CRC covers the start byte through the end of its page.
  - Each later page CRC covers only its own 32 bytes.
  - The stream ends after the CRC of the page that ends at address 127.
- R7: A status read returns status bytes from the start address up to address 7, then a CRC over those bytes as read at that time.
- R8: After the final CRC of any read, every read slot returns FFh until a line reset.
- R9: A line reset at any point aborts the command. The next received byte is taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_reset | input | 1 | Link-level reset pulse; aborts the current command |
| rx_valid | input | 1 | A byte from the master is present on rx_byte |
| rx_byte | input | 8 | Byte received from the master |
| tx_req | input | 1 | Master requests one read slot (a byte) |
| tx_valid | output | 1 | Reply byte valid, one cycle after tx_req |
| tx_byte | output | 8 | Reply byte |
| mem_addr | output | 7 | Read address to the main array |
| mem_rdata | input | 8 | Main array data at mem_addr, same cycle |
| stat_addr | output | 3 | Read address to the status array |
| stat_rdata | input | 8 | Status array data at stat_addr, same cycle |

## Verification
The assertions assume the following about the link:
- tx_req and rx_valid are single-cycle pulses with at least one idle cycle between them.
- They are never high together.
- The array data stays constant while a read slot is being served.

The stimulus meets these rules because every byte and every slot is driven by a task that raises the strobe for one cycle and then idles for one cycle. Array contents change only between commands. Within these rules the stimulus sweeps every status start address and a spread of main start addresses, including page-last bytes, the final byte and start addresses that alias through ignored address bits.

// File: rtl/addonly_rd_pkg.sv
package addonly_rd_pkg;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_TAL,
      PH_TAH,
      PH_ECHO,
      PH_DATA,
      PH_CRC,
      PH_ONES
   } rd_phase_t;

   typedef enum logic [1:0] {
      MD_NONE,
      MD_MEM,
      MD_PAGE,
      MD_STAT
   } rd_mode_t;

   localparam logic [7:0] CMD_MEM  = 8'hF0;
   localparam logic [7:0] CMD_PAGE = 8'hC3;
   localparam logic [7:0] CMD_STAT = 8'hAA;

   function automatic rd_mode_t decode_cmd(input logic [7:0] b);
      case (b)
         CMD_MEM:  decode_cmd = MD_MEM;
         CMD_PAGE: decode_cmd = MD_PAGE;
         CMD_STAT: decode_cmd = MD_STAT;
         default:  decode_cmd = MD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/addonly_rd_crc_step.sv
module addonly_rd_crc_step #(
   parameter int          CRC_W = 8,
   parameter int          DAT_W = 8,
   parameter logic [CRC_W-1:0] POLY_R = 8'h8C
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [DAT_W-1:0] dat_in,
   output logic [CRC_W-1:0] crc_out
);
   logic [CRC_W-1:0] stage [DAT_W+1];

   assign stage[0] = crc_in;

   generate
      for (genvar i = 0; i < DAT_W; i++) begin : g_bit
         logic fb;
         assign fb = stage[i][0] ^ dat_in[i];
         assign stage[i+1] = fb ? ((stage[i] >> 1) ^ POLY_R) : (stage[i] >> 1);
      end
   endgenerate

   assign crc_out = stage[DAT_W];
endmodule

// File: rtl/addonly_rd_field_end.sv
module addonly_rd_field_end
   import addonly_rd_pkg::*;
#(
   parameter int MAIN_AW = 7,
   parameter int PAGE_AW = 5,
   parameter int STAT_AW = 3
) (
   input  rd_mode_t           mode,
   input  logic [MAIN_AW-1:0] addr,
   output logic               seg_last,
   output logic               field_last
);
   logic main_last;
   logic page_last;
   logic stat_last;

   assign main_last = &addr;
   assign page_last = &addr[PAGE_AW-1:0];
   assign stat_last = &addr[STAT_AW-1:0];

   always_comb begin
      case (mode)
         MD_MEM:  seg_last = main_last;
         MD_PAGE: seg_last = page_last;
         MD_STAT: seg_last = stat_last;
         default: seg_last = 1'b0;
      endcase
      field_last = (mode == MD_STAT) ? stat_last : main_last;
   end
endmodule

// File: rtl/addonly_rd_engine.sv
module addonly_rd_engine
   import addonly_rd_pkg::*;
#(
   parameter int MAIN_AW = 7,
   parameter int PAGE_AW = 5,
   parameter int STAT_AW = 3,
   parameter logic [7:0] POLY_R = 8'h8C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_reset,
   input  logic               rx_valid,
   input  logic [7:0]         rx_byte,
   input  logic               tx_req,
   output logic               tx_valid,
   output logic [7:0]         tx_byte,
   output logic [MAIN_AW-1:0] mem_addr,
   input  logic [7:0]         mem_rdata,
   output logic [STAT_AW-1:0] stat_addr,
   input  logic [7:0]         stat_rdata
);
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] ONES = '1;

   generate
      if (MAIN_AW > BYTE_W || MAIN_AW < 1) begin : g_bad_main
         $error("MAIN_AW must be within 1..8");
      end
      if (PAGE_AW >= MAIN_AW || PAGE_AW < 1) begin : g_bad_page
         $error("PAGE_AW must be below MAIN_AW");
      end
      if (STAT_AW > BYTE_W || STAT_AW < 1) begin : g_bad_stat
         $error("STAT_AW must be within 1..8");
      end
   endgenerate

   rd_phase_t          phase_q;
   rd_mode_t           mode_q;
   logic [MAIN_AW-1:0] addr_q;
   logic [7:0]         crc_q;

   logic [7:0]         rd_byte;
   logic [7:0]         crc_din;
   logic [7:0]         crc_nxt;
   logic               seg_last;
   logic               field_last;
   logic               rx_phase;
   rd_mode_t           new_mode;

   assign rd_byte  = (mode_q == MD_STAT) ? stat_rdata : mem_rdata;
   assign rx_phase = (phase_q == PH_CMD) || (phase_q == PH_TAL) || (phase_q == PH_TAH);
   assign crc_din  = rx_phase ? rx_byte : rd_byte;
   assign new_mode = decode_cmd(rx_byte);

   assign mem_addr  = addr_q;
   assign stat_addr = addr_q[STAT_AW-1:0];

   addonly_rd_crc_step #(
      .CRC_W (8),
      .DAT_W (BYTE_W),
      .POLY_R(POLY_R)
   ) crc_i (
      .crc_in (crc_q),
      .dat_in (crc_din),
      .crc_out(crc_nxt)
   );

   addonly_rd_field_end #(
      .MAIN_AW(MAIN_AW),
      .PAGE_AW(PAGE_AW),
      .STAT_AW(STAT_AW)
   ) end_i (
      .mode      (mode_q),
      .addr      (addr_q),
      .seg_last  (seg_last),
      .field_last(field_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_CMD;
         mode_q   <= MD_NONE;
         addr_q   <= '0;
         crc_q    <= '0;
         tx_valid <= 1'b0;
         tx_byte  <= ONES;
      end else if (line_reset) begin
         phase_q  <= PH_CMD;
         mode_q   <= MD_NONE;
         addr_q   <= '0;
         crc_q    <= '0;
         tx_valid <= 1'b0;
         tx_byte  <= ONES;
      end else begin
         tx_valid <= tx_req;
         if (tx_req) begin
            tx_byte <= ONES;
         end
         case (phase_q)
            PH_CMD: begin
               if (rx_valid) begin
                  mode_q <= new_mode;
                  crc_q  <= crc_nxt;
                  phase_q <= (new_mode == MD_NONE) ? PH_ONES : PH_TAL;
               end
            end
            PH_TAL: begin
               if (rx_valid) begin
                  if (mode_q == MD_STAT) begin
                     addr_q <= MAIN_AW'(rx_byte[STAT_AW-1:0]);
                  end else begin
                     addr_q <= rx_byte[MAIN_AW-1:0];
                  end
                  crc_q   <= crc_nxt;
                  phase_q <= PH_TAH;
               end
            end
            PH_TAH: begin
               if (rx_valid) begin
                  crc_q   <= crc_nxt;
                  phase_q <= PH_ECHO;
               end
            end
            PH_ECHO: begin
               if (tx_req) begin
                  tx_byte <= crc_q;
                  crc_q   <= '0;
                  phase_q <= PH_DATA;
               end
            end
            PH_DATA: begin
               if (tx_req) begin
                  tx_byte <= rd_byte;
                  crc_q   <= crc_nxt;
                  if (seg_last) begin
                     phase_q <= PH_CRC;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                  end
               end
            end
            PH_CRC: begin
               if (tx_req) begin
                  tx_byte <= crc_q;
                  crc_q   <= '0;
                  if (mode_q == MD_PAGE && !field_last) begin
                     addr_q  <= addr_q + 1'b1;
                     phase_q <= PH_DATA;
                  end else begin
                     phase_q <= PH_ONES;
                  end
               end
            end
            default: begin
               phase_q <= PH_ONES;
            end
         endcase
      end
   end
endmodule

// File: rtl/addonly_rd_checker.sv
module addonly_rd_checker
   import addonly_rd_pkg::*;
#(
   parameter int MAIN_AW = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               line_reset,
   input logic               tx_req,
   input logic               tx_valid,
   input logic [7:0]         tx_byte,
   input rd_phase_t          phase,
   input rd_mode_t           mode,
   input logic [MAIN_AW-1:0] addr
);
   a_r4_reply_follows_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !line_reset) |=> tx_valid);

   a_r4_no_spurious_reply: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_req));

   a_r8_ones_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ONES && tx_req && !line_reset) |=> (tx_byte == 8'hFF));

   a_r9_abort_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      line_reset |=> (phase == PH_CMD && !tx_valid));

   a_r5_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && mode == MD_MEM && tx_req && !line_reset && addr != '1)
      |=> (addr == MAIN_AW'($past(addr) + 1'b1)));

   a_r2_addr_stable_outside_data: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ECHO && !line_reset) |=> $stable(addr));
endmodule

bind addonly_rd_engine addonly_rd_checker #(.MAIN_AW(MAIN_AW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_reset(line_reset),
   .tx_req    (tx_req),
   .tx_valid  (tx_valid),
   .tx_byte   (tx_byte),
   .phase     (phase_q),
   .mode      (mode_q),
   .addr      (addr_q)
);

// File: tb/addonly_rd_engine_tb_top.sv
module addonly_rd_engine_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_reset = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       tx_req = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic [6:0] mem_addr;
   logic [7:0] mem_rdata;
   logic [2:0] stat_addr;
   logic [7:0] stat_rdata;

   logic [7:0] mem  [128];
   logic [7:0] stat [8];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   assign mem_rdata  = mem[mem_addr];
   assign stat_rdata = stat[stat_addr];

   addonly_rd_engine dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_reset(line_reset),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .tx_req    (tx_req),
      .tx_valid  (tx_valid),
      .tx_byte   (tx_byte),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .stat_addr (stat_addr),
      .stat_rdata(stat_rdata)
   );

   function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r = c;
      for (int i = 0; i < 8; i++) begin
         logic fb = r[0] ^ d[i];
         r = r >> 1;
         if (fb) r = r ^ 8'h8C;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic read_slot(input logic [7:0] exp, input string tag);
      @(negedge clk);
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
      chk(tx_valid === 1'b1, "R4", int'(tx_valid), 1);
      chk(tx_byte === exp, tag, int'(tx_byte), int'(exp));
   endtask

   task automatic pulse_line_reset();
      @(negedge clk);
      line_reset = 1'b1;
      @(negedge clk);
      line_reset = 1'b0;
   endtask

   task automatic run_read(input logic [7:0] cmd, input logic [7:0] ta1,
                           input logic [7:0] ta2, input bit early, input string dtag);
      logic [7:0] c;
      send_byte(cmd);
      if (early) read_slot(8'hFF, "R4");
      send_byte(ta1);
      send_byte(ta2);
      c = crc_upd(crc_upd(crc_upd(8'h00, cmd), ta1), ta2);
      read_slot(c, "R3");
      c = 8'h00;
      if (cmd == 8'hAA) begin
         for (int a = int'(ta1 & 8'h07); a < 8; a++) begin
            read_slot(stat[a], dtag);
            c = crc_upd(c, stat[a]);
         end
         read_slot(c, "R7");
      end else if (cmd == 8'hF0) begin
         for (int a = int'(ta1 & 8'h7F); a < 128; a++) begin
            read_slot(mem[a], dtag);
            c = crc_upd(c, mem[a]);
         end
         read_slot(c, "R5");
      end else begin
         for (int a = int'(ta1 & 8'h7F); a < 128; a++) begin
            read_slot(mem[a], dtag);
            c = crc_upd(c, mem[a]);
            if ((a % 32) == 31) begin
               read_slot(c, "R6");
               c = 8'h00;
            end
         end
      end
      for (int k = 0; k < 3; k++) read_slot(8'hFF, "R8");
      pulse_line_reset();
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      for (int i = 0; i < 8; i++)   stat[i] = 8'((i * 29) ^ 8'hA5);

      repeat (3) @(negedge clk);
      chk(tx_valid === 1'b0, "R4", int'(tx_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(tx_valid === 1'b0, "R4", int'(tx_valid), 0);

      // R5 whole-memory read from several starts
      run_read(8'hF0, 8'h00, 8'h00, 1'b0, "R5");
      run_read(8'hF0, 8'h05, 8'h00, 1'b0, "R5");
      run_read(8'hF0, 8'h7F, 8'h00, 1'b0, "R5");
      // R2 aliasing of ignored address bits
      run_read(8'hF0, 8'hFC, 8'h5A, 1'b0, "R2");
      run_read(8'hAA, 8'hF9, 8'h33, 1'b0, "R2");
      // R6 paged read, page-last and mid-page starts
      run_read(8'hC3, 8'h00, 8'h00, 1'b0, "R6");
      run_read(8'hC3, 8'h1F, 8'h00, 1'b0, "R6");
      run_read(8'hC3, 8'h28, 8'h00, 1'b0, "R6");
      run_read(8'hC3, 8'h7F, 8'h01, 1'b0, "R6");
      // R7 every status start address
      for (int s = 0; s < 8; s++) run_read(8'hAA, 8'(s), 8'h00, 1'b0, "R7");
      // R7 status CRC follows current contents
      stat[3] = stat[3] ^ 8'h40;
      stat[6] = 8'h00;
      run_read(8'hAA, 8'h00, 8'h00, 1'b0, "R7");
      // R4 slot before address complete
      run_read(8'hF0, 8'h70, 8'h00, 1'b1, "R4");

      // R1 unknown command gives ones
      send_byte(8'h33);
      send_byte(8'h00);
      send_byte(8'h00);
      for (int k = 0; k < 3; k++) read_slot(8'hFF, "R1");
      pulse_line_reset();
      // R1 accepted commands still work afterwards
      run_read(8'hAA, 8'h06, 8'h00, 1'b0, "R1");

      // R9 abort mid-stream
      send_byte(8'hF0);
      send_byte(8'h10);
      send_byte(8'h00);
      read_slot(crc_upd(crc_upd(crc_upd(8'h00, 8'hF0), 8'h10), 8'h00), "R3");
      for (int a = 16; a < 20; a++) read_slot(mem[a], "R9");
      pulse_line_reset();
      chk(tx_valid === 1'b0, "R9", int'(tx_valid), 0);
      run_read(8'hAA, 8'h02, 8'h00, 1'b0, "R9");
      // R9 abort between address bytes
      send_byte(8'hC3);
      send_byte(8'h40);
      pulse_line_reset();
      run_read(8'hC3, 8'h5E, 8'h00, 1'b0, "R9");

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule